// File: doc/BRIEF.md
# Zero-Aware Min-Sum Check Node

This block is the check-node computation of a normalized min-sum LDPC decoder. In one cycle it takes the variable-to-check messages of all the edges of one check node, up to a parameterized degree. It returns one check-to-variable message per edge. Each outgoing magnitude is the smallest incoming magnitude among the other edges, scaled by three quarters. Each outgoing sign is the product of the signs of the other edges.

The block saves work by counting the incoming messages whose magnitude is exactly zero. With two or more zeros, every output is zero and no search result is used. With exactly one zero, only the edge that sent the zero receives a computed value, and all other edges receive zero. A separate input tells the node that all of its neighbouring variable nodes are deactivated. In that case the registered outputs keep their previous contents. A skip flag comes with every result so that the decoder can count the check-node operations it avoided. Message storage and scheduling are left to the surrounding decoder.

Top module: `zmcn_check_node`

## Requirements
- R1: Messages are sign-magnitude, MSG_W bits per edge (default 7, a 3.3 magnitude with the sign in the top bit). Edge k occupies bits [k*MSG_W +: MSG_W] of the flat buses. An input whose magnitude field is 0 counts as zero whatever its sign bit.
- R2: With no zero input, output k has magnitude floor(m/2)+floor(m/4), where m is the minimum input magnitude over all edges except k.
- R3: With no zero input, the sign of output k is the XOR of the sign bits of all other edges. A zero input contributes a positive sign (0).
- R4: Any output whose magnitude is zero carries sign bit 0.
- R5: With two or more zero inputs and the deactivation input low, all outputs are zero and the skip flag is 1.
- R6: With exactly one zero input at edge z, output z follows R2 and R3 over the other edges, all other outputs are zero, and the skip flag is 0.
- R7: When the all-neighbours-deactivated input is high with a valid input, the outputs keep their previous values and the skip flag is 1, whatever the zero count.
- R8: The result appears one clock after a valid input with the output valid high for that one cycle. Without a valid input, the output valid is 0 and the outputs and skip flag hold.
- R9: After reset, the output valid, the skip flag and all outputs are 0.
- R10: When several edges share the minimum magnitude, every output takes that shared minimum, including the output of the lowest-indexed edge that holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input messages present this cycle |
| allDeact | input | 1 | All neighbouring variable nodes deactivated |
| v2cFlat | input | DEGREE*MSG_W | Incoming messages, edge 0 in the low bits |
| outValid | output | 1 | Result registered from the previous valid input |
| skipped | output | 1 | The last valid operation was skipped |
| c2vFlat | output | DEGREE*MSG_W | Outgoing messages, edge 0 in the low bits |

## Verification
Two paths can both claim the same input: the deactivation hold and the zero-count shortcut. A vector that is marked deactivated and also carries two or more zeros must leave the registers untouched rather than clear them. The bench provokes this with directed vectors and with random ones that mix a high zero density with the deactivation bit. It judges the result by comparing the outputs against the previously loaded result in its model. A second overlap is the single-zero case where the surviving minimum scales down to zero. Here the one computed edge must also obey the positive-zero rule. A directed vector with a minimum of 1 checks that case.

// File: rtl/zmcn_pkg.sv
package zmcn_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;          // capture a new result into the output register
    logic forceZero;     // two or more zero inputs: all lanes zero
    logic onlyZeroEdge;  // one zero input: only that lane is computed
  } cnStrobe_t;
endpackage

// File: rtl/zmcn_control.sv
module zmcn_control
  import zmcn_pkg::*;
#(
  parameter int DEGREE = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              allDeact,
  input  logic [DEGREE-1:0] zeroMask,
  output cnStrobe_t         strobe,
  output logic              outValid,
  output logic              skipped
);
  localparam int CNT_W = $clog2(DEGREE + 1);

  logic [CNT_W-1:0] zeroCount;
  logic twoOrMore;

  always_comb begin
    zeroCount = '0;
    for (int k = 0; k < DEGREE; k++) begin
      zeroCount = zeroCount + CNT_W'(zeroMask[k]);
    end
  end

  assign twoOrMore           = (zeroCount >= CNT_W'(2));
  assign strobe.load         = inValid && !allDeact;
  assign strobe.forceZero    = twoOrMore;
  assign strobe.onlyZeroEdge = (zeroCount == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      skipped  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        skipped <= allDeact || twoOrMore;
      end
    end
  end
endmodule

// File: rtl/zmcn_datapath.sv
module zmcn_datapath
  import zmcn_pkg::*;
#(
  parameter int DEGREE = 6,
  parameter int MSG_W  = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DEGREE*MSG_W-1:0] v2cFlat,
  input  cnStrobe_t               strobe,
  output logic [DEGREE-1:0]       zeroMask,
  output logic [DEGREE*MSG_W-1:0] c2vFlat
);
  localparam int MAG_W = MSG_W - 1;
  localparam int IDX_W = (DEGREE > 1) ? $clog2(DEGREE) : 1;

  logic [MAG_W-1:0] mag [DEGREE];
  logic [DEGREE-1:0] sgn;
  logic [MAG_W-1:0] min1, min2;
  logic [IDX_W-1:0] min1Idx;
  logic signParity;
  logic [DEGREE*MSG_W-1:0] nextFlat;

  // unpack lanes; a zero magnitude counts as positive
  for (genvar k = 0; k < DEGREE; k++) begin : g_unpack
    assign mag[k]      = v2cFlat[k*MSG_W +: MAG_W];
    assign zeroMask[k] = (mag[k] == '0);
    assign sgn[k]      = v2cFlat[k*MSG_W + MAG_W] & ~zeroMask[k];
  end

  // two-minimum search, first minimum at lowest index on ties
  always_comb begin
    min1    = '1;
    min2    = '1;
    min1Idx = '0;
    for (int k = 0; k < DEGREE; k++) begin
      if (mag[k] < min1) begin
        min2    = min1;
        min1    = mag[k];
        min1Idx = IDX_W'(k);
      end else if (mag[k] < min2) begin
        min2 = mag[k];
      end
    end
  end

  assign signParity = ^sgn;

  for (genvar k = 0; k < DEGREE; k++) begin : g_lane
    logic [MAG_W-1:0] selMag, scaled, gatedMag;
    logic laneSign, keep;
    assign selMag   = (min1Idx == IDX_W'(k)) ? min2 : min1;
    assign scaled   = MAG_W'(selMag >> 1) + MAG_W'(selMag >> 2);
    assign keep     = !strobe.forceZero && (!strobe.onlyZeroEdge || zeroMask[k]);
    assign gatedMag = keep ? scaled : '0;
    assign laneSign = (signParity ^ sgn[k]) & (gatedMag != '0);
    assign nextFlat[k*MSG_W +: MSG_W] = {laneSign, gatedMag};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      c2vFlat <= '0;
    end else if (strobe.load) begin
      c2vFlat <= nextFlat;
    end
  end
endmodule

// File: rtl/zmcn_check_node.sv
module zmcn_check_node
  import zmcn_pkg::*;
#(
  parameter int DEGREE = 6,
  parameter int MSG_W  = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    allDeact,
  input  logic [DEGREE*MSG_W-1:0] v2cFlat,
  output logic                    outValid,
  output logic                    skipped,
  output logic [DEGREE*MSG_W-1:0] c2vFlat
);
  cnStrobe_t strobe;
  logic [DEGREE-1:0] zeroMask;

  zmcn_control #(.DEGREE(DEGREE)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .allDeact(allDeact),
    .zeroMask(zeroMask), .strobe(strobe), .outValid(outValid), .skipped(skipped)
  );

  zmcn_datapath #(.DEGREE(DEGREE), .MSG_W(MSG_W)) u_dp (
    .clk(clk), .rstN(rstN), .v2cFlat(v2cFlat), .strobe(strobe),
    .zeroMask(zeroMask), .c2vFlat(c2vFlat)
  );
endmodule

// File: rtl/zmcn_checker.sv
module zmcn_checker #(
  parameter int DEGREE = 6,
  parameter int MSG_W  = 7
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    allDeact,
  input logic [DEGREE*MSG_W-1:0] v2cFlat,
  input logic                    outValid,
  input logic                    skipped,
  input logic [DEGREE*MSG_W-1:0] c2vFlat
);
  localparam int MAG_W = MSG_W - 1;

  function automatic int countZeros(logic [DEGREE*MSG_W-1:0] v);
    int n = 0;
    for (int k = 0; k < DEGREE; k++) if (v[k*MSG_W +: MAG_W] == '0) n++;
    return n;
  endfunction

  function automatic logic noNegZero(logic [DEGREE*MSG_W-1:0] v);
    logic ok = 1'b1;
    for (int k = 0; k < DEGREE; k++)
      if (v[k*MSG_W +: MAG_W] == '0 && v[k*MSG_W + MAG_W]) ok = 1'b0;
    return ok;
  endfunction

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && $stable(c2vFlat) && $stable(skipped));  // R8
  AST_DEACT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    inValid && allDeact |=> $stable(c2vFlat) && skipped);  // R7
  AST_MULTI_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !allDeact && countZeros(v2cFlat) >= 2 |=> c2vFlat == '0 && skipped);  // R5
  AST_SINGLE_ZERO_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !allDeact && countZeros(v2cFlat) == 1 |=> !skipped);  // R6
  AST_POS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> noNegZero(c2vFlat));  // R4
endmodule

bind zmcn_check_node zmcn_checker #(.DEGREE(DEGREE), .MSG_W(MSG_W)) u_chk (.*);

// File: tb/zmcn_check_node_bench.sv
module zmcn_check_node_bench;
  localparam int DEGREE = 6;
  localparam int MSG_W  = 7;
  localparam int MAG_W  = MSG_W - 1;
  localparam int W      = DEGREE * MSG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic allDeact = 1'b0;
  logic [W-1:0] v2cFlat = '0;
  logic outValid, skipped;
  logic [W-1:0] c2vFlat;

  int vectors = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [W-1:0] modelOut = '0;
  logic modelSkip = 1'b0;

  always #2.5 clk = ~clk;

  zmcn_check_node #(.DEGREE(DEGREE), .MSG_W(MSG_W)) u_zmcn_check_node (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model of the requirements
  task automatic model(input logic [W-1:0] v, output logic [W-1:0] o, output logic sk);
    int zeros = 0;
    o = '0;
    for (int k = 0; k < DEGREE; k++) if (v[k*MSG_W +: MAG_W] == 0) zeros++;
    sk = (zeros >= 2);
    for (int k = 0; k < DEGREE; k++) begin
      int m = (1 << MAG_W) - 1;
      int s = 0;
      int sc;
      for (int j = 0; j < DEGREE; j++) begin
        if (j != k) begin
          int mj = int'(v[j*MSG_W +: MAG_W]);
          if (mj < m) m = mj;
          if (mj != 0) s ^= int'(v[j*MSG_W + MAG_W]);
        end
      end
      sc = m / 2 + m / 4;
      if (zeros >= 2) sc = 0;
      if (zeros == 1 && v[k*MSG_W +: MAG_W] != 0) sc = 0;
      if (sc == 0) s = 0;
      o[k*MSG_W +: MSG_W] = {s[0], MAG_W'(sc)};
    end
  endtask

  task automatic apply(input logic iv, input logic dz, input logic [W-1:0] v, input string req);
    logic [W-1:0] e;
    logic es;
    inValid = iv;
    allDeact = dz;
    v2cFlat = v;
    if (iv) begin
      if (dz) modelSkip = 1'b1;
      else begin
        model(v, e, es);
        modelOut = e;
        modelSkip = es;
      end
    end
    @(negedge clk);
    check({req, " outValid"}, W'(outValid), W'(iv));
    check({req, " c2v"}, c2vFlat, modelOut);
    check({req, " skipped"}, W'(skipped), W'(modelSkip));
  endtask

  function automatic logic [W-1:0] lanes(input int m0, m1, m2, m3, m4, m5, input int signs);
    logic [W-1:0] r;
    int m[6] = '{m0, m1, m2, m3, m4, m5};
    for (int k = 0; k < DEGREE; k++) r[k*MSG_W +: MSG_W] = {signs[k], MAG_W'(m[k])};
    return r;
  endfunction

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 outValid", W'(outValid), '0);
    check("R9 skipped", W'(skipped), '0);
    check("R9 c2v", c2vFlat, '0);
    rstN = 1'b1;
    @(negedge clk);

    apply(1, 0, lanes(10, 20, 5, 30, 63, 8, 6'b000101), "R2 R3 basic");
    apply(1, 0, lanes(63, 63, 63, 63, 63, 63, 6'b111111), "R2 max magnitude");
    apply(1, 0, lanes(7, 7, 9, 7, 12, 40, 6'b010010), "R10 tie");
    apply(1, 0, lanes(1, 4, 9, 11, 12, 40, 6'b000010), "R4 scaled to zero");
    apply(1, 0, lanes(0, 4, 9, 11, 12, 40, 6'b011111), "R6 R1 negative zero edge");
    apply(1, 0, lanes(22, 1, 9, 0, 12, 3, 6'b100110), "R6 R4 one zero min one");
    apply(1, 0, lanes(22, 0, 9, 0, 12, 3, 6'b111111), "R5 two zeros");
    apply(1, 0, lanes(33, 14, 9, 2, 12, 3, 6'b001100), "R2 reload");
    apply(1, 1, lanes(0, 0, 0, 5, 6, 7, 6'b000000), "R7 deact with zeros");
    apply(0, 0, lanes(1, 2, 3, 4, 5, 6, 6'b000000), "R8 idle hold");
    apply(1, 1, lanes(9, 9, 9, 9, 9, 9, 6'b000000), "R7 deact hold");

    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] v;
      for (int k = 0; k < DEGREE; k++) begin
        logic [MAG_W-1:0] mg = ($urandom % 6 == 0) ? '0 : MAG_W'($urandom);
        v[k*MSG_W +: MSG_W] = {1'($urandom), mg};
      end
      apply(($urandom % 8) != 0, ($urandom % 10) == 0, v, "R2 R3 R5 R6 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule